// File: doc/BRIEF.md
# SPI Receive Buffer with Read Pointer

This block sits between the receive shift stage of an SPI controller and the register read port. Each time a serial frame finishes, the frame is written into a small circular store, provided a slot is free. A read access on the pop port hands back the oldest stored frame and moves a read pointer on by one. The pointer is visible, so software always knows which slot the next read will return.

When the store is full, one extra completed frame can wait in the shift stage. A further frame arriving while both the store and the shift stage are occupied is an overflow. A configuration input decides whether that newest frame replaces the waiting one or is thrown away.

Two sticky status bits are kept. One reports overflow. The other requests draining, and it clears only under a DMA or software condition once the store is empty.

Top module: `spiRxPopBuffer`

## Requirements
- R1: After reset, `count` is 0, `popPtr` is 0, and both `ovfFlag` and `drainFlag` are 0.
- R2: A frame presented on `frameValid`/`frameData` while `count` < DEPTH (default 4) is stored at the next clock edge, and `count` rises by one.
- R3: A pop (`popReq` high with `count` > 0) returns on `popData` the oldest stored frame in arrival order and advances `popPtr` by one. After slot DEPTH-1 the pointer wraps to 0, so `popPtr` always names the slot the next pop reads.
- R4: A pop while `count` is 0 leaves `count` and `popPtr` unchanged.
- R5: A store and a pop in the same cycle leave `count` unchanged, and `popPtr` still advances.
- R6: A frame that arrives while the store is full, with no frame already waiting, is held in the shift stage without overflow. It enters the store in the same cycle that a pop frees a slot, so `count` stays at DEPTH across that pop.
- R7: A frame that arrives while the store is full, a frame is waiting and no pop occurs sets `ovfFlag` at the next edge.
- R8: On overflow with `overwriteEn`=1 the new frame replaces the waiting frame. With `overwriteEn`=0 the new frame is discarded and the waiting frame is kept.
- R9: `ovfFlag` stays set until a cycle with `clrOvf`=1 and no new overflow. A new overflow in the same cycle as `clrOvf` keeps it set.
- R10: `drainFlag` is 1 in every cycle in which `count` is nonzero.
- R11: With `count` at 0, `drainFlag` clears at the edge after `dmaDone`=1 or `clrDrain`=1. While frames remain stored, neither input clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | Shift stage finished a frame this cycle |
| frameData | input | DATA_W | The completed frame |
| popReq | input | 1 | Read access to the pop port |
| overwriteEn | input | 1 | 1: an overflowing frame replaces the waiting frame; 0: it is dropped |
| clrOvf | input | 1 | Write-one-to-clear for the overflow flag |
| clrDrain | input | 1 | Write-one-to-clear for the drain flag |
| dmaDone | input | 1 | DMA reports that its pop read has finished |
| popData | output | DATA_W | Frame at the read pointer |
| popPtr | output | PTR_W | Slot the next pop returns |
| count | output | CNT_W | Number of stored frames |
| ovfFlag | output | 1 | Sticky overflow status |
| drainFlag | output | 1 | Drain request status |

## Verification
A store and a pop can fall in the same cycle. This happens either when a new frame arrives with a read, or when a waiting frame moves into the slot a read has just freed. The bench provokes both cases with the store full and with it partly filled. It judges them through `count` and `popPtr` after the edge, and through a scoreboard that matches every popped frame to the arrival order a requirement-level model predicts, including which frame survived an overflow.

// File: rtl/rxbufPkg.sv
package rxbufPkg;
  // Strobes from control to datapath for one clock cycle
  typedef struct packed {
    logic pushEn;    // write one slot of the store
    logic pushSel;   // 1: write the waiting frame, 0: write the incoming frame
    logic holdLoad;  // load the incoming frame into the waiting stage
  } strobeT;
endpackage

// File: rtl/rxbufCtrl.sv
module rxbufCtrl
  import rxbufPkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameValid,
  input  logic             popReq,
  input  logic             overwriteEn,
  input  logic             clrOvf,
  input  logic             clrDrain,
  input  logic             dmaDone,
  output strobeT           stb,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag,
  output logic             drainFlag
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  logic             holdValid, holdNext;
  logic             isFull, isEmpty, popOk, roomNow, ovfEvt;
  logic [CNT_W-1:0] countNext;

  assign isFull  = (count == FULL_CNT);
  assign isEmpty = (count == '0);
  assign popOk   = popReq && !isEmpty;
  assign roomNow = !isFull || popOk;
  assign ovfEvt  = frameValid && holdValid && !roomNow;

  always_comb begin
    stb      = '0;
    holdNext = holdValid;
    if (holdValid) begin
      if (roomNow) begin
        stb.pushEn   = 1'b1;
        stb.pushSel  = 1'b1;
        stb.holdLoad = frameValid;
        holdNext     = frameValid;
      end else if (frameValid && overwriteEn) begin
        stb.holdLoad = 1'b1;
      end
    end else if (frameValid) begin
      if (roomNow) begin
        stb.pushEn = 1'b1;
      end else begin
        stb.holdLoad = 1'b1;
        holdNext     = 1'b1;
      end
    end
  end

  always_comb begin
    countNext = count;
    if (stb.pushEn && !popOk)      countNext = count + 1'b1;
    else if (!stb.pushEn && popOk) countNext = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      holdValid <= 1'b0;
      ovfFlag   <= 1'b0;
      drainFlag <= 1'b0;
    end else begin
      if (stb.pushEn) wrPtr <= nextPtr(wrPtr);
      if (popOk)      rdPtr <= nextPtr(rdPtr);
      count     <= countNext;
      holdValid <= holdNext;
      if (ovfEvt)      ovfFlag <= 1'b1;
      else if (clrOvf) ovfFlag <= 1'b0;
      if (countNext != '0)          drainFlag <= 1'b1;
      else if (clrDrain || dmaDone) drainFlag <= 1'b0;
    end
  end

  // Assertions
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
  p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && count != '0 && rdPtr == LAST_PTR) |=> rdPtr == '0);
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && count == '0) |=> ($stable(count) && $stable(rdPtr)));
  p_push_pop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pushEn && popReq && count != '0) |=> $stable(count));
  p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && holdValid && isFull && !popReq) |=> ovfFlag);
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !clrOvf) |=> ovfFlag);
  p_drain_level_r10: assert property (@(posedge clk) disable iff (!rstN)
    (count != '0) |-> drainFlag);
  p_drain_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (drainFlag && !clrDrain && !dmaDone) |=> drainFlag);
endmodule

// File: rtl/rxbufData.sv
module rxbufData
  import rxbufPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [DATA_W-1:0] frameData,
  output logic [DATA_W-1:0] popData
);
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] slotQ [DEPTH];
  logic [DATA_W-1:0] pushWord;

  assign pushWord = stb.pushSel ? holdReg : frameData;

  always_ff @(posedge clk) begin
    if (!rstN)             holdReg <= '0;
    else if (stb.holdLoad) holdReg <= frameData;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)                                      slotQ[e] <= '0;
      else if (stb.pushEn && wrPtr == PTR_W'(e)) slotQ[e] <= pushWord;
    end
  end

  assign popData = slotQ[rdPtr];

  // The waiting frame, not the incoming one, lands in the store
  p_hold_enters_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pushEn && stb.pushSel) |=> slotQ[$past(wrPtr)] == $past(holdReg));
  p_direct_push_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pushEn && !stb.pushSel) |=> slotQ[$past(wrPtr)] == $past(frameData));
endmodule

// File: rtl/spiRxPopBuffer.sv
module spiRxPopBuffer
  import rxbufPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic [DATA_W-1:0] frameData,
  input  logic              popReq,
  input  logic              overwriteEn,
  input  logic              clrOvf,
  input  logic              clrDrain,
  input  logic              dmaDone,
  output logic [DATA_W-1:0] popData,
  output logic [PTR_W-1:0]  popPtr,
  output logic [CNT_W-1:0]  count,
  output logic              ovfFlag,
  output logic              drainFlag
);
  strobeT           stb;
  logic [PTR_W-1:0] wrPtr;

  rxbufCtrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .popReq(popReq),
    .overwriteEn(overwriteEn), .clrOvf(clrOvf), .clrDrain(clrDrain),
    .dmaDone(dmaDone), .stb(stb), .wrPtr(wrPtr), .rdPtr(popPtr),
    .count(count), .ovfFlag(ovfFlag), .drainFlag(drainFlag)
  );

  rxbufData #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrPtr(wrPtr), .rdPtr(popPtr),
    .frameData(frameData), .popData(popData)
  );
endmodule

// File: tb/spiRxPopBuffer_test.sv
`timescale 1ns/1ps
module spiRxPopBuffer_test;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 4;
  localparam int PTR_W  = 2;
  localparam int CNT_W  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameValid = 1'b0, popReq = 1'b0, overwriteEn = 1'b0;
  logic clrOvf = 1'b0, clrDrain = 1'b0, dmaDone = 1'b0;
  logic [DATA_W-1:0] frameData = '0;
  logic [DATA_W-1:0] popData;
  logic [PTR_W-1:0]  popPtr;
  logic [CNT_W-1:0]  count;
  logic ovfFlag, drainFlag;

  int nTests = 0, nFail = 0;
  bit finished = 1'b0;
  string curTag = "R3";

  // Requirement-level model
  logic [DATA_W-1:0] expQ[$];
  int mCount = 0, mPtr = 0;
  bit mHoldV = 0, mOvf = 0, mDrain = 0;
  logic [DATA_W-1:0] mHold = '0;

  always #10 clk = ~clk;

  spiRxPopBuffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameData(frameData),
    .popReq(popReq), .overwriteEn(overwriteEn), .clrOvf(clrOvf),
    .clrDrain(clrDrain), .dmaDone(dmaDone), .popData(popData),
    .popPtr(popPtr), .count(count), .ovfFlag(ovfFlag), .drainFlag(drainFlag)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: compare every valid pop with the scoreboard queue (R3 ordering)
  always @(posedge clk) begin
    if (rstN && popReq && count != '0) begin
      if (expQ.size() == 0) check(curTag, "pop with empty scoreboard", 1, 0);
      else begin
        logic [DATA_W-1:0] e;
        e = expQ.pop_front();
        check(curTag, "popData", int'(popData), int'(e));
      end
    end
  end

  // Driver: one cycle of stimulus, model update, then compare at the negedge
  task automatic step(input string tag, input bit fv, input logic [DATA_W-1:0] fd,
                      input bit pop, input bit ow, input bit cO, input bit cD, input bit dm);
    bit popOk, room, ovfSet;
    curTag = tag;
    popOk  = pop && mCount > 0;
    room   = (mCount < DEPTH) || popOk;
    ovfSet = 0;
    if (mHoldV) begin
      if (room) begin
        expQ.push_back(mHold); mCount++;
        if (fv) mHold = fd; else mHoldV = 0;
      end else if (fv) begin
        ovfSet = 1;
        if (ow) mHold = fd;
      end
    end else if (fv) begin
      if (room) begin expQ.push_back(fd); mCount++; end
      else begin mHold = fd; mHoldV = 1; end
    end
    if (popOk) begin mCount--; mPtr = (mPtr + 1) % DEPTH; end
    if (ovfSet) mOvf = 1; else if (cO) mOvf = 0;
    if (mCount != 0) mDrain = 1; else if (cD || dm) mDrain = 0;
    frameValid = fv; frameData = fd; popReq = pop; overwriteEn = ow;
    clrOvf = cO; clrDrain = cD; dmaDone = dm;
    @(posedge clk);
    @(negedge clk);
    frameValid = 0; popReq = 0; clrOvf = 0; clrDrain = 0; dmaDone = 0;
    check(tag, "count", int'(count), mCount);
    check(tag, "popPtr", int'(popPtr), mPtr);
    check(tag, "ovfFlag", int'(ovfFlag), int'(mOvf));
    check(tag, "drainFlag", int'(drainFlag), int'(mDrain));
  endtask

  task automatic push(input string tag, input logic [DATA_W-1:0] d, input bit ow);
    step(tag, 1, d, 0, ow, 0, 0, 0);
  endtask
  task automatic pop(input string tag);
    step(tag, 0, '0, 1, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1", "count", int'(count), 0);
    check("R1", "popPtr", int'(popPtr), 0);
    check("R1", "ovfFlag", int'(ovfFlag), 0);
    check("R1", "drainFlag", int'(drainFlag), 0);

    // R2, R10: stores raise count, drain flag follows at once
    push("R2", 16'h1111, 0);
    check("R10", "drain after first store", int'(drainFlag), 1);
    push("R2", 16'h2222, 0);
    push("R2", 16'h3333, 0);
    // R3: arrival order, pointer advance
    pop("R3"); pop("R3"); pop("R3");
    // R11: empty but not yet acknowledged keeps drain set
    check("R11", "drain held when empty", int'(drainFlag), 1);
    step("R11", 0, '0, 0, 0, 0, 0, 1);
    check("R11", "drain cleared by dmaDone", int'(drainFlag), 0);
    // R4: pop while empty
    pop("R4");
    check("R4", "count after empty pop", int'(count), 0);
    check("R4", "popPtr after empty pop", int'(popPtr), 3);

    // R3 wrap and R5 same-cycle store+pop, partly filled and full
    push("R3", 16'hA001, 0);
    step("R5", 1, 16'hA002, 1, 0, 0, 0, 0);
    check("R3", "pointer wrapped", int'(popPtr), 0);
    push("R5", 16'hA003, 0);
    push("R5", 16'hA004, 0);
    push("R5", 16'hA005, 0);
    check("R2", "full count", int'(count), 4);
    step("R5", 1, 16'hA006, 1, 0, 0, 0, 0);
    check("R5", "count unchanged when full", int'(count), 4);

    // R6: one frame waits while full, enters on the next pop
    push("R6", 16'hB001, 0);
    check("R6", "no overflow for first waiting frame", int'(ovfFlag), 0);
    check("R6", "count stays full", int'(count), 4);
    pop("R6");
    check("R6", "waiting frame moved in", int'(count), 4);

    // R7, R8: overflow with discard
    push("R7", 16'hB002, 0);   // waits
    push("R8", 16'hB003, 0);   // overflow, dropped
    check("R7", "overflow set", int'(ovfFlag), 1);
    // R11: clear inputs ignored while frames remain
    step("R11", 0, '0, 0, 0, 0, 1, 1);
    check("R11", "drain kept while nonempty", int'(drainFlag), 1);
    // R9: new overflow beats the clear
    step("R9", 1, 16'hB004, 0, 0, 1, 0, 0);
    check("R9", "set wins over clear", int'(ovfFlag), 1);
    step("R9", 0, '0, 0, 0, 0, 0, 0);
    check("R9", "sticky", int'(ovfFlag), 1);
    step("R9", 0, '0, 0, 0, 1, 0, 0);
    check("R9", "cleared by write", int'(ovfFlag), 0);
    // R8: overwrite mode replaces the waiting frame
    push("R8", 16'hC001, 1);
    check("R8", "overwrite overflow", int'(ovfFlag), 1);
    for (int i = 0; i < 5; i++) pop("R8");
    check("R8", "drained count", int'(count), 0);
    // R11: software clear once empty
    step("R11", 0, '0, 0, 0, 0, 1, 0);
    check("R11", "drain cleared by write", int'(drainFlag), 0);
    check("R3", "scoreboard empty", expQ.size(), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule